// File: doc/BRIEF.md
# Banked ROM Dump Sequencer

This block is the bus master that reads an entire four-bank program ROM through an 8-bit multiplexed bus. The ROM holds an internal address counter. The block loads that counter with a three-byte sequence written onto the shared bus. It then hands the bus back to the ROM and steps the counter one strobe per byte. Each byte it reads is passed downstream as a tagged stream item.

For each bank, the sequencer applies a bank code on two select lines. It then pulls the reset line and the bus-direction line low, one after the other, and writes three load bytes, each latched by a low strobe pulse. After that it lets go of the bus and raises the two lines again. From then on, every strobe pulse moves the ROM one address on, and the sequencer samples the bus just before each of those pulses. The banks are visited in ascending code order, and a done flag marks the end of the last one. The strobe width and the settle delay before each sample are runtime inputs, so the timing can be matched to slow parts.

Each read byte goes out on a valid/ready stream with its bank code and 16-bit address. While the consumer holds ready low, the sequencer stops: no strobe is issued until the held item has been taken.

Top module: `rom_dump_seq`

## Requirements
- R1: After reset, and while idle or done, `mrst_o`, `di_o`, `it_o` and `st_o` are all high, `bus_oe_o` is low and `dat_valid_o` is low.
- R2: For each bank, `bank_sel_o` takes the bank code at least one clock before `mrst_o` falls. `di_o` falls at least one clock after `mrst_o`. Bank codes are used in the order 0, 1, 2, 3.
- R3: With the bus driven, three bytes are written in this order: 0x00, the low byte of `ADDR_FIRST`, then the high byte of `ADDR_FIRST` (0x00, 0x00, 0x20 by default). Each byte is followed by exactly one low pulse on `st_o`, which returns high before the next byte.
- R4: After the third load pulse, `bus_oe_o` drops first. `di_o` then rises while `mrst_o` is still low, and `mrst_o` rises after `di_o`.
- R5: Every low pulse on `st_o`, for loading or for stepping, lasts max(`pulse_len_i`, 1) clocks.
- R6: Before each sample, the bus is left to settle for at least max(`settle_len_i`, 1) clocks after `mrst_o` rises or after a step pulse. Each emitted byte equals the ROM content at its tagged bank and address.
- R7: `bus_oe_o` is high only while `di_o` is low. `di_o` is low for at least one clock before `bus_oe_o` rises, and is still low in the clock in which `bus_oe_o` falls.
- R8: Within each bank, items carry the addresses `ADDR_FIRST` through `ADDR_LAST` in ascending order, one item per address. No step pulse is issued while an item is pending.
- R9: While `dat_valid_o` is high and `dat_ready_i` is low, the item stays valid and its byte, bank and address stay unchanged.
- R10: `done_o` rises after the last item of bank 3 is accepted, after 4 × (`ADDR_LAST` − `ADDR_FIRST` + 1) items in total. It stays high until the next start.
- R11: `start_i` has no effect while a dump is running. The item sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a full dump when idle or done |
| pulse_len_i | input | CNT_W | Strobe low time in clocks (0 treated as 1) |
| settle_len_i | input | CNT_W | Settle time before sampling in clocks (0 treated as 1) |
| bus_in_i | input | 8 | Value read from the shared bus |
| bus_out_o | output | 8 | Value driven onto the shared bus |
| bus_oe_o | output | 1 | Bus driver enable |
| bank_sel_o | output | 2 | Bank select code |
| mrst_o | output | 1 | ROM counter-load/reset line, active low |
| di_o | output | 1 | Bus direction line, low = master drives |
| it_o | output | 1 | Auxiliary control line, held high |
| st_o | output | 1 | Strobe, active-low pulse |
| dat_valid_o | output | 1 | Stream item valid |
| dat_ready_i | input | 1 | Stream consumer ready |
| dat_byte_o | output | 8 | Stream item data byte |
| dat_bank_o | output | 2 | Stream item bank code |
| dat_addr_o | output | 16 | Stream item address |
| done_o | output | 1 | All banks dumped |

## Verification
The bench stands in for the ROM. It latches the bytes written under the strobe, sets its counter from them and steps that counter on each strobe. If the load bytes were wrong or in the wrong order, every byte after that would come from the wrong address and the scoreboard would flag it. Consumer back-pressure is applied at irregular points, and a start pulse is sent in the middle of a run. If the design stepped during a stall or restarted on that pulse, addresses would be skipped or repeated. The bench also times each strobe pulse at two width settings, including zero. It checks the order of the bank, reset, direction and drive-enable edges, because a design that drove the bus early or released the lines in the wrong order would fight the ROM on the bus.

// File: rtl/rom_dump_pkg.sv
// Shared types for the banked ROM dump sequencer.
package rom_dump_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_BANK,
        S_MRST,
        S_TAKE,
        S_DRIVE,
        S_LDLO,
        S_LDHI,
        S_DROP,
        S_GIVE,
        S_RUN,
        S_SETTLE,
        S_SAMPLE,
        S_WAIT,
        S_INCLO,
        S_INCHI,
        S_NEXT,
        S_DONE
    } seq_state_t;

    localparam int LOAD_BYTES = 3;

endpackage

// File: rtl/dump_dwell_timer.sv
// Dwell timer: counts clocks spent in the current sequencer state.
// Assumes restart_i is high in the cycle the state changes. expired_o goes
// high in the last cycle of a dwell of max(limit_i,1) clocks.
module dump_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // expiry once cnt+1 reaches the limit (a zero limit expires at once)
    assign expired_o = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit_i};

    // count clocks within a state, clear on each state change
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dump_position.sv
// Bank and address position tracker for the dump.
// clear_i restarts at bank 0 and ADDR_FIRST. bank_step_i moves to the next
// bank and reloads ADDR_FIRST. addr_step_i moves to the next address.
module dump_position #(
    parameter int                BANK_W     = 2,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_FIRST = 16'h2000,
    parameter logic [ADDR_W-1:0] ADDR_LAST  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              bank_step_i,
    input  logic              addr_step_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bank_last_o,
    output logic              addr_last_o
);
    localparam logic [BANK_W-1:0] BANK_MAX = {BANK_W{1'b1}};

    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;

    // bank and address registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            bank_q <= '0;
            addr_q <= ADDR_FIRST;
        end else if (bank_step_i) begin
            bank_q <= bank_q + 1'b1;
            addr_q <= ADDR_FIRST;
        end else if (addr_step_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign bank_o      = bank_q;
    assign addr_o      = addr_q;
    assign bank_last_o = (bank_q == BANK_MAX);
    assign addr_last_o = (addr_q == ADDR_LAST);
endmodule

// File: rtl/dump_out_slot.sv
// One-entry output slot of the dump stream.
// load_i captures a new item. It assumes load_i is only raised while the slot
// is empty. The item is released on a valid/ready handshake.
module dump_out_slot #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] byte_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o
);
    // valid flag: set on load, cleared on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else if (load_i) begin
            valid_o <= 1'b1;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o <= '0;
            bank_o <= '0;
            addr_o <= '0;
        end else if (load_i) begin
            byte_o <= byte_i;
            bank_o <= bank_i;
            addr_o <= addr_i;
        end
    end
endmodule

// File: rtl/rom_dump_seq.sv
// Banked ROM dump sequencer (top).
// For each of the bank codes it loads the ROM's internal address counter
// through three strobed bus bytes, then steps through ADDR_FIRST..ADDR_LAST,
// emitting every byte on a valid/ready stream. Assumes ADDR_W is 16, so the
// start address fits in the two load bytes after the leading zero byte.
// All control outputs are decoded from the registered state.
module rom_dump_seq #(
    parameter int                CNT_W      = 8,
    parameter int                DATA_W     = 8,
    parameter int                BANK_W     = 2,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_FIRST = 16'h2000,
    parameter logic [ADDR_W-1:0] ADDR_LAST  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  pulse_len_i,
    input  logic [CNT_W-1:0]  settle_len_i,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic [DATA_W-1:0] bus_out_o,
    output logic              bus_oe_o,
    output logic [BANK_W-1:0] bank_sel_o,
    output logic              mrst_o,
    output logic              di_o,
    output logic              it_o,
    output logic              st_o,
    output logic              dat_valid_o,
    input  logic              dat_ready_i,
    output logic [DATA_W-1:0] dat_byte_o,
    output logic [BANK_W-1:0] dat_bank_o,
    output logic [ADDR_W-1:0] dat_addr_o,
    output logic              done_o
);
    import rom_dump_pkg::*;

    localparam int IDX_W = $clog2(LOAD_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LOAD_BYTES - 1);

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              expired;
    logic [CNT_W-1:0]  dwell_lim;
    logic              pos_clear, bank_step, addr_step;
    logic [BANK_W-1:0] cur_bank;
    logic [ADDR_W-1:0] cur_addr;
    logic              bank_last, addr_last;
    logic [DATA_W-1:0] load_byte;

    // dwell limit: settle time in the settle state, strobe width otherwise
    assign dwell_lim = (state_q == S_SETTLE) ? settle_len_i : pulse_len_i;

    dump_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state_d != state_q),
        .limit_i   (dwell_lim),
        .expired_o (expired)
    );

    assign pos_clear = (state_q == S_IDLE || state_q == S_DONE) && start_i;
    assign bank_step = (state_q == S_NEXT);
    assign addr_step = (state_q == S_INCHI);

    dump_position #(
        .BANK_W     (BANK_W),
        .ADDR_W     (ADDR_W),
        .ADDR_FIRST (ADDR_FIRST),
        .ADDR_LAST  (ADDR_LAST)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (pos_clear),
        .bank_step_i (bank_step),
        .addr_step_i (addr_step),
        .bank_o      (cur_bank),
        .addr_o      (cur_addr),
        .bank_last_o (bank_last),
        .addr_last_o (addr_last)
    );

    dump_out_slot #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (state_q == S_SAMPLE),
        .byte_i  (bus_in_i),
        .bank_i  (cur_bank),
        .addr_i  (cur_addr),
        .ready_i (dat_ready_i),
        .valid_o (dat_valid_o),
        .byte_o  (dat_byte_o),
        .bank_o  (dat_bank_o),
        .addr_o  (dat_addr_o)
    );

    // next-state logic of the dump sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: if (start_i) state_d = S_BANK;
            S_BANK:   state_d = S_MRST;
            S_MRST:   state_d = S_TAKE;
            S_TAKE:   state_d = S_DRIVE;
            S_DRIVE:  state_d = S_LDLO;
            S_LDLO:   if (expired) state_d = S_LDHI;
            S_LDHI:   state_d = (idx_q == IDX_LAST) ? S_DROP : S_DRIVE;
            S_DROP:   state_d = S_GIVE;
            S_GIVE:   state_d = S_RUN;
            S_RUN:    state_d = S_SETTLE;
            S_SETTLE: if (expired) state_d = S_SAMPLE;
            S_SAMPLE: state_d = S_WAIT;
            S_WAIT: begin
                if (!dat_valid_o) begin
                    if (!addr_last)     state_d = S_INCLO;
                    else if (bank_last) state_d = S_DONE;
                    else                state_d = S_NEXT;
                end
            end
            S_INCLO:  if (expired) state_d = S_INCHI;
            S_INCHI:  state_d = S_SETTLE;
            S_NEXT:   state_d = S_BANK;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // load-byte index: cleared per bank, advanced after each load strobe
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_BANK) idx_q <= '0;
        else if (state_q == S_LDHI)      idx_q <= idx_q + 1'b1;
    end

    // load byte: leading zero, then start address low byte, then high byte
    always_comb begin
        unique case (idx_q)
            IDX_W'(1): load_byte = ADDR_FIRST[7:0];
            IDX_W'(2): load_byte = ADDR_FIRST[15:8];
            default:   load_byte = 8'h00;
        endcase
    end

    // control line decode from the registered state
    always_comb begin
        bus_oe_o = (state_q == S_DRIVE) || (state_q == S_LDLO) || (state_q == S_LDHI);
        di_o     = !(bus_oe_o || state_q == S_TAKE || state_q == S_DROP);
        mrst_o   = di_o && !(state_q == S_MRST || state_q == S_GIVE);
        st_o     = !(state_q == S_LDLO || state_q == S_INCLO);
    end

    assign bus_out_o  = bus_oe_o ? load_byte : '0;
    assign bank_sel_o = cur_bank;
    assign it_o       = 1'b1;
    assign done_o     = (state_q == S_DONE);
endmodule

// File: rtl/rom_dump_seq_chk.sv
// Checker for rom_dump_seq. It watches the top-level ports only and is
// bound to every instance of the top module.
module rom_dump_seq_chk #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_oe_o,
    input logic [BANK_W-1:0] bank_sel_o,
    input logic              mrst_o,
    input logic              di_o,
    input logic              it_o,
    input logic              st_o,
    input logic              dat_valid_o,
    input logic              dat_ready_i,
    input logic [DATA_W-1:0] dat_byte_o,
    input logic [BANK_W-1:0] dat_bank_o,
    input logic [ADDR_W-1:0] dat_addr_o,
    input logic              done_o
);
    AST_DRIVE_NEEDS_DI: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> !di_o); // R7
    AST_DRIVE_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(!di_o)); // R7
    AST_DRIVE_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe_o) |-> !di_o); // R7
    AST_BANK_BEFORE_MRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mrst_o) |-> $stable(bank_sel_o) && di_o); // R2
    AST_DI_AFTER_MRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(di_o) |-> $past(!mrst_o)); // R2
    AST_MRST_AFTER_DI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrst_o) |-> $past(di_o) && !bus_oe_o); // R4
    AST_NO_STEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid_o |-> st_o); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid_o && !dat_ready_i |=> dat_valid_o && $stable(dat_byte_o)
            && $stable(dat_bank_o) && $stable(dat_addr_o)); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> mrst_o && di_o && st_o && it_o && !bus_oe_o && !dat_valid_o); // R1
endmodule

bind rom_dump_seq rom_dump_seq_chk #(
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_oe_o    (bus_oe_o),
    .bank_sel_o  (bank_sel_o),
    .mrst_o      (mrst_o),
    .di_o        (di_o),
    .it_o        (it_o),
    .st_o        (st_o),
    .dat_valid_o (dat_valid_o),
    .dat_ready_i (dat_ready_i),
    .dat_byte_o  (dat_byte_o),
    .dat_bank_o  (dat_bank_o),
    .dat_addr_o  (dat_addr_o),
    .done_o      (done_o)
);

// File: tb/rom_dump_seq_tb.sv
// Scoreboard bench: a behavioural ROM answers the bus, a driver task queues
// the expected items, a monitor pops and compares every accepted item.
module rom_dump_seq_tb;
    localparam logic [15:0] FIRST = 16'hFFF4;
    localparam logic [15:0] LAST  = 16'hFFFF;
    localparam int PER_BANK = int'(LAST) - int'(FIRST) + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  pulse_len = 8'd0;
    logic [7:0]  settle_len = 8'd0;
    logic [7:0]  bus_in;
    logic [7:0]  bus_out;
    logic        bus_oe, mrst, di, it, st;
    logic [1:0]  bank_sel;
    logic        dvalid, dready = 1'b1;
    logic [7:0]  dbyte;
    logic [1:0]  dbank;
    logic [15:0] daddr;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int n_items = 0;
    int exp_bank_seq = 0;
    int cyc = 0;

    typedef struct packed {logic [1:0] bank; logic [15:0] addr; logic [7:0] data;} item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    rom_dump_seq #(.ADDR_FIRST(FIRST), .ADDR_LAST(LAST)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pulse_len_i(pulse_len),
        .settle_len_i(settle_len), .bus_in_i(bus_in), .bus_out_o(bus_out),
        .bus_oe_o(bus_oe), .bank_sel_o(bank_sel), .mrst_o(mrst), .di_o(di),
        .it_o(it), .st_o(st), .dat_valid_o(dvalid), .dat_ready_i(dready),
        .dat_byte_o(dbyte), .dat_bank_o(dbank), .dat_addr_o(daddr), .done_o(done)
    );

    function automatic logic [7:0] rom_val(input logic [1:0] b, input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {b, 6'h15};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: queue the expected stream for one full dump
    task automatic push_dump();
        for (int b = 0; b < 4; b++)
            for (int a = int'(FIRST); a <= int'(LAST); a++)
                exp_q.push_back({2'(b), 16'(a), rom_val(2'(b), 16'(a))});
    endtask

    // behavioural ROM state
    logic [1:0]  rom_bank = 2'd0;
    logic [15:0] rom_addr = 16'd0;
    logic [7:0]  ld_buf [3];
    int          ld_cnt = 0;
    int          st_low = 0;
    logic        p_st = 1'b1, p_di = 1'b1, p_mrst = 1'b1, p_oe = 1'b0;
    logic [1:0]  p_bank = 2'd0;

    assign bus_in = di ? rom_val(rom_bank, rom_addr) : 8'h00;

    // ROM model plus edge-order and pulse-width monitors
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_mrst && !mrst) begin
                chk(bank_sel == 2'(exp_bank_seq), "R2 bank order", bank_sel, exp_bank_seq);
                chk(p_bank == bank_sel && di && !bus_oe, "R2 bank before mrst", p_bank, bank_sel);
                exp_bank_seq++;
                ld_cnt = 0;
            end
            if (p_di && !di) chk(!mrst && !bus_oe, "R7 di falls first", bus_oe, 0);
            if (!p_oe && bus_oe) chk(!p_di, "R7 di low before drive", p_di, 0);
            if (!p_di && di) chk(!bus_oe && !mrst && ld_cnt == 3, "R4 release order", ld_cnt, 3);
            if (!p_mrst && mrst) chk(di, "R4 mrst after di", di, 1);
            if (!st) st_low++;
            if (!p_st && st) begin
                chk(st_low == ((pulse_len == 0) ? 1 : int'(pulse_len)), "R5 strobe width",
                    st_low, (pulse_len == 0) ? 1 : int'(pulse_len));
                if (!di) begin
                    if (ld_cnt < 3) ld_buf[ld_cnt] = bus_out;
                    if (ld_cnt == 0) rom_bank = bank_sel;
                    ld_cnt++;
                    if (ld_cnt == 3) begin
                        chk(ld_buf[0] == 8'h00 && ld_buf[1] == FIRST[7:0] && ld_buf[2] == FIRST[15:8],
                            "R3 load bytes", {ld_buf[0], ld_buf[1], ld_buf[2]}, {8'h00, FIRST[7:0], FIRST[15:8]});
                        rom_addr = {ld_buf[2], ld_buf[1]};
                    end
                end else if (mrst) begin
                    rom_addr = rom_addr + 1'b1;
                end
                st_low = 0;
            end
        end
        p_st = st; p_di = di; p_mrst = mrst; p_oe = bus_oe; p_bank = bank_sel;
    end

    // monitor: compare accepted items, check stall holding
    logic   p_stall = 1'b0;
    item_t  p_item;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_stall)
                chk(dvalid && {dbank, daddr, dbyte} == p_item, "R9 stall hold",
                    {dbank, daddr, dbyte}, p_item);
            if (dvalid && dready) begin
                item_t e;
                n_items++;
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected item", {dbank, daddr, dbyte}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(dbank == e.bank && daddr == e.addr, "R8 item tag",
                        {dbank, daddr}, {e.bank, e.addr});
                    chk(dbyte == e.data, "R6 item byte", dbyte, e.data);
                end
            end
            p_stall = dvalid && !dready;
            p_item  = {dbank, daddr, dbyte};
        end
    end

    // consumer ready pattern with occasional long stalls
    initial begin
        forever begin
            @(negedge clk);
            dready = !((cyc % 7) == 3 || (cyc % 53) < 6);
        end
    end

    task automatic run_dump(input logic [7:0] pl, input logic [7:0] sl, input bit poke);
        int w = 0;
        pulse_len = pl; settle_len = sl;
        exp_bank_seq = 0; n_items = 0;
        push_dump();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && w < 20000) begin
            @(negedge clk); w++;
            if (poke && w == 150) start = 1'b1;   // R11: start ignored mid-run
            else start = 1'b0;
        end
        chk(w < 20000, "R10 watchdog", w, 20000);
        chk(done, "R10 done raised", done, 1);
        chk(n_items == 4 * PER_BANK && exp_q.size() == 0, "R10 item total", n_items, 4 * PER_BANK);
        chk(exp_bank_seq == 4, "R2 banks visited", exp_bank_seq, 4);
        chk(n_items == 4 * PER_BANK, "R11 sequence intact", n_items, 4 * PER_BANK);
        repeat (5) @(negedge clk);
        chk(done && mrst && di && st && it && !bus_oe, "R1 lines after done",
            {done, mrst, di, st, it, bus_oe}, 6'b111110);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mrst && di && it && st && !bus_oe && !dvalid && !done, "R1 reset state",
            {mrst, di, it, st, bus_oe, dvalid, done}, 7'b1111000);
        run_dump(8'd0, 8'd0, 1'b1);
        run_dump(8'd3, 8'd2, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule